// File: doc/BRIEF.md
# SPI Burst Register Access Port

This block is an SPI slave front end for a small byte-wide register file. The register file has a 32-entry address space, and 22 of those entries are populated. Every transaction opens with a command byte. The command byte selects read or write mode and loads a 5-bit register pointer. Each further byte clocked while chip select stays low accesses the next register in sequence. The block decodes the access into receive-queue pop strobes and transmit-queue push strobes for two message channels. The message queues themselves sit outside the block. The block sees them only through head data, flags and strobes.

SCLK, chip select and MOSI are brought into the system clock domain through synchronizers and are sampled there. The master must therefore keep each SCLK phase several system clocks long. Each channel owns three registers:
- a high data byte;
- a low data byte;
- a control byte whose top bit selects short-word messages.

When short-word mode is on, the high byte is stepped over during automatic pointer advance. A combined flag byte is frozen at the start of every transaction. The remaining addresses hold general-purpose bytes.

Top module: `spi_burst_port`

## Requirements
- R1: The command byte is the first byte after chip select falls. Its bit 7 set means a write burst and bit 7 clear means a read burst. Bits 4..0 load the register pointer, and bits 6..5 have no effect. All bytes move MSB first in SPI mode 0.
- R2: Each byte after the command byte accesses the register at the pointer, then advances the pointer. A write burst stores the byte there. A read burst leaves all register contents unchanged.
- R3: Advancing from address 0x15 or from any higher address gives 0x00. Addresses 0x16..0x1F read as 0x00 and ignore writes.
- R4: The byte shifted out during the command slot is the register at the pointer left by the previous transaction. In each later slot, the byte shifted out is the value held before that slot by the register the slot accesses. The pointer persists across transactions.
- R5: Address 0x04 returns a flag byte captured when chip select falls. Bit 2c+0 is the receive-not-empty flag of channel c, bit 2c+1 is the transmit-not-full flag of channel c, and bits 7..4 are 0. Flag changes during the burst do not show.
- R6: Control bytes sit at 0x05 (channel 0) and 0x06 (channel 1), and bit 7 of each is the short-word mode. When that bit is set, automatic advance steps over the channel's high data address (0x00 for channel 0, 0x02 for channel 1).
- R7: A data slot that accesses a low data address (0x01 for channel 0, 0x03 for channel 1), in read or write mode, gives one single-cycle pop pulse on that channel. No other access pops, and neither does the command slot.
- R8: A write to a low data address gives one push pulse on that channel. The transmit word is {high byte, written byte}, or {0x00, written byte} when short-word mode is on. A read never pushes.
- R9: When chip select rises partway through a byte, that byte is dropped. It causes no write, no pop, no push and no pointer change.
- R10: After reset the pointer is 0x00, all stored bytes are 0x00, MISO is low and no strobe is active.
- R11: The high and low data addresses read the channel's receive head word: the high address returns bits 15..8 and the low address returns bits 7..0. Addresses 0x07..0x15 read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, low while deselected |
| rx_head_i | input | 32 | Receive head words, channel c in bits 16c+15..16c |
| rx_not_empty_i | input | 2 | Receive queue holds data, one bit per channel |
| tx_not_full_i | input | 2 | Transmit queue has room, one bit per channel |
| rx_pop_o | output | 2 | One-cycle receive pop strobe per channel |
| tx_push_o | output | 2 | One-cycle transmit push strobe per channel |
| tx_word_o | output | 16 | Word that accompanies a push strobe |

## Verification
A wrong pointer shows at MISO within the next byte slot. The next byte slot, or at the latest the next command slot, then returns a byte from the wrong address, and a strobe may appear on the wrong channel. A lost or early status capture shows only when the flag address is read in a burst that changes the flags after chip select falls. Such a burst is exercised for that reason. Bit-counter or partial-byte faults show as extra pops or pushes, which the bench counts at the strobe pins, and the pointer then drifts one register.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int ADDR_W     = 5;
    localparam int BYTE_W     = 8;
    localparam int NUM_CH     = 2;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int LAST_ADDR  = 21;
    localparam int STAT_ADDR  = 2 * NUM_CH;
    localparam int CTRL_BASE  = STAT_ADDR + 1;
    localparam int GP_BASE    = CTRL_BASE + NUM_CH;
    localparam int GP_COUNT   = LAST_ADDR - GP_BASE + 1;
    localparam int SHORT_BIT  = BYTE_W - 1;
    localparam int WR_BIT     = BYTE_W - 1;
    localparam int CNT_W      = $clog2(BYTE_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        addr_t                          ptr;
        logic                           cmd;
        logic                           wr;
        byte_t                          snap;
        logic [NUM_CH-1:0][BYTE_W-1:0]  ctrl;
        logic [NUM_CH-1:0][BYTE_W-1:0]  hi;
        logic [GP_COUNT-1:0][BYTE_W-1:0] gp;
        logic [NUM_CH-1:0]              pop;
        logic [NUM_CH-1:0]              push;
        logic [WORD_W-1:0]              word;
    } rf_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        byte_t            rx;
        byte_t            tx;
        logic             sclk_prev;
        logic             cs_prev;
    } sh_state_t;
endpackage

// File: rtl/spi_burst_sync.sv
module spi_burst_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
    import spi_burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_i,
    input  logic  cs_n_i,
    input  logic  mosi_i,
    input  logic  load_en_i,
    input  byte_t load_byte_i,
    output logic  cs_fall_o,
    output logic  byte_done_o,
    output byte_t byte_val_o,
    output logic  miso_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    sh_state_t s_d, s_q;
    logic      sclk_rise, sclk_fall;

    always_comb begin
        s_d          = s_q;
        s_d.sclk_prev = sclk_i;
        s_d.cs_prev   = cs_n_i;
        sclk_rise    = sclk_i && !s_q.sclk_prev;
        sclk_fall    = !sclk_i && s_q.sclk_prev;
        cs_fall_o    = !cs_n_i && s_q.cs_prev;
        byte_done_o  = 1'b0;
        byte_val_o   = {s_q.rx[BYTE_W-2:0], mosi_i};
        if (cs_n_i) begin
            s_d.cnt = '0;
        end else begin
            if (sclk_rise) begin
                s_d.rx = byte_val_o;
                if (s_q.cnt == LAST_BIT) begin
                    s_d.cnt     = '0;
                    byte_done_o = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (sclk_fall && s_q.cnt != '0) begin
                s_d.tx = {s_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
        if (load_en_i) begin
            s_d.tx = load_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt       <= '0;
            s_q.rx        <= '0;
            s_q.tx        <= '0;
            s_q.sclk_prev <= 1'b0;
            s_q.cs_prev   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso_o = !cs_n_i && s_q.tx[BYTE_W-1];
endmodule

// File: rtl/spi_burst_regfile.sv
module spi_burst_regfile
    import spi_burst_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_fall_i,
    input  logic                     byte_done_i,
    input  byte_t                    byte_val_i,
    input  logic [NUM_CH*WORD_W-1:0] rx_head_i,
    input  logic [NUM_CH-1:0]        rx_not_empty_i,
    input  logic [NUM_CH-1:0]        tx_not_full_i,
    output logic                     load_en_o,
    output byte_t                    load_byte_o,
    output logic [NUM_CH-1:0]        rx_pop_o,
    output logic [NUM_CH-1:0]        tx_push_o,
    output logic [WORD_W-1:0]        tx_word_o,
    output logic                     cmd_phase_o,
    output addr_t                    ptr_o,
    output logic [NUM_CH-1:0]        short_o
);
    rf_state_t s_d, s_q;
    byte_t     stat_live;

    function automatic byte_t read_reg(addr_t a, byte_t st, rf_state_t s,
                                       logic [NUM_CH*WORD_W-1:0] rx);
        int    ai;
        byte_t v;
        ai = int'(a);
        v  = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ai == 2 * ch)         v = rx[ch*WORD_W+BYTE_W +: BYTE_W];
            if (ai == 2 * ch + 1)     v = rx[ch*WORD_W +: BYTE_W];
            if (ai == CTRL_BASE + ch) v = s.ctrl[ch];
        end
        if (ai == STAT_ADDR) v = st;
        for (int g = 0; g < GP_COUNT; g++) begin
            if (ai == GP_BASE + g) v = s.gp[g];
        end
        return v;
    endfunction

    function automatic addr_t next_ptr(addr_t p, logic [NUM_CH-1:0][BYTE_W-1:0] ctrl);
        int n;
        n = (int'(p) >= LAST_ADDR) ? 0 : int'(p) + 1;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (n == 2 * ch && ctrl[ch][SHORT_BIT]) n = n + 1;
        end
        return addr_t'(n);
    endfunction

    always_comb begin
        stat_live = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            stat_live[2*ch]   = rx_not_empty_i[ch];
            stat_live[2*ch+1] = tx_not_full_i[ch];
        end
    end

    always_comb begin
        int ai;
        s_d         = s_q;
        s_d.pop     = '0;
        s_d.push    = '0;
        load_en_o   = 1'b0;
        load_byte_o = '0;
        ai          = int'(s_q.ptr);
        if (cs_fall_i) begin
            s_d.cmd     = 1'b1;
            s_d.snap    = stat_live;
            load_en_o   = 1'b1;
            load_byte_o = read_reg(s_q.ptr, stat_live, s_q, rx_head_i);
        end else if (byte_done_i) begin
            load_en_o = 1'b1;
            if (s_q.cmd) begin
                s_d.cmd     = 1'b0;
                s_d.wr      = byte_val_i[WR_BIT];
                s_d.ptr     = byte_val_i[ADDR_W-1:0];
                load_byte_o = read_reg(s_d.ptr, s_q.snap, s_q, rx_head_i);
            end else begin
                if (s_q.wr) begin
                    for (int ch = 0; ch < NUM_CH; ch++) begin
                        if (ai == 2 * ch)         s_d.hi[ch]   = byte_val_i;
                        if (ai == CTRL_BASE + ch) s_d.ctrl[ch] = byte_val_i;
                    end
                    for (int g = 0; g < GP_COUNT; g++) begin
                        if (ai == GP_BASE + g) s_d.gp[g] = byte_val_i;
                    end
                end
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (ai == 2 * ch + 1) begin
                        s_d.pop[ch] = 1'b1;
                        if (s_q.wr) begin
                            s_d.push[ch] = 1'b1;
                            s_d.word     = s_q.ctrl[ch][SHORT_BIT] ?
                                           {{BYTE_W{1'b0}}, byte_val_i} :
                                           {s_q.hi[ch], byte_val_i};
                        end
                    end
                end
                s_d.ptr     = next_ptr(s_q.ptr, s_d.ctrl);
                load_byte_o = read_reg(s_d.ptr, s_q.snap, s_d, rx_head_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_short
            assign short_o[ch] = s_q.ctrl[ch][SHORT_BIT];
        end
    endgenerate

    assign rx_pop_o    = s_q.pop;
    assign tx_push_o   = s_q.push;
    assign tx_word_o   = s_q.word;
    assign cmd_phase_o = s_q.cmd;
    assign ptr_o       = s_q.ptr;
endmodule

// File: rtl/spi_burst_port.sv
module spi_burst_port
    import spi_burst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spi_sclk,
    input  logic                     spi_cs_n,
    input  logic                     spi_mosi,
    output logic                     spi_miso,
    input  logic [NUM_CH*WORD_W-1:0] rx_head_i,
    input  logic [NUM_CH-1:0]        rx_not_empty_i,
    input  logic [NUM_CH-1:0]        tx_not_full_i,
    output logic [NUM_CH-1:0]        rx_pop_o,
    output logic [NUM_CH-1:0]        tx_push_o,
    output logic [WORD_W-1:0]        tx_word_o
);
    logic [2:0]        pins_s;
    logic              sclk_s, cs_high_s, mosi_s;
    logic              cs_fall_w, byte_done_w, load_en_w, cmd_phase_w;
    byte_t             byte_val_w, load_byte_w;
    addr_t             ptr_w;
    logic [NUM_CH-1:0] short_w;

    spi_burst_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sclk, spi_cs_n, spi_mosi}),
        .level_o (pins_s)
    );

    assign sclk_s    = pins_s[2];
    assign cs_high_s = pins_s[1];
    assign mosi_s    = pins_s[0];

    spi_burst_shifter shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_s),
        .cs_n_i      (cs_high_s),
        .mosi_i      (mosi_s),
        .load_en_i   (load_en_w),
        .load_byte_i (load_byte_w),
        .cs_fall_o   (cs_fall_w),
        .byte_done_o (byte_done_w),
        .byte_val_o  (byte_val_w),
        .miso_o      (spi_miso)
    );

    spi_burst_regfile regs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_fall_i      (cs_fall_w),
        .byte_done_i    (byte_done_w),
        .byte_val_i     (byte_val_w),
        .rx_head_i      (rx_head_i),
        .rx_not_empty_i (rx_not_empty_i),
        .tx_not_full_i  (tx_not_full_i),
        .load_en_o      (load_en_w),
        .load_byte_o    (load_byte_w),
        .rx_pop_o       (rx_pop_o),
        .tx_push_o      (tx_push_o),
        .tx_word_o      (tx_word_o),
        .cmd_phase_o    (cmd_phase_w),
        .ptr_o          (ptr_w),
        .short_o        (short_w)
    );
endmodule

// File: rtl/spi_burst_port_chk.sv
module spi_burst_port_chk
    import spi_burst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_high_s,
    input logic              byte_done_w,
    input byte_t             byte_val_w,
    input logic              cmd_phase_w,
    input addr_t             ptr_w,
    input logic [NUM_CH-1:0] short_w,
    input logic [NUM_CH-1:0] rx_pop_o,
    input logic [NUM_CH-1:0] tx_push_o,
    input logic [WORD_W-1:0] tx_word_o
);
    assert_pop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop_o));

    assert_pop_after_data_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_o != '0) |-> $past(byte_done_w && !cmd_phase_w));

    assert_push_with_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_o != '0) |-> (tx_push_o == rx_pop_o));

    assert_push_low_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_o != '0) |-> (tx_word_o[BYTE_W-1:0] == $past(byte_val_w)));

    assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_w && !cmd_phase_w) |=> (int'(ptr_w) <= LAST_ADDR));

    assert_no_pop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_high_s) |-> (rx_pop_o == '0 && tx_push_o == '0));

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_skip
            assert_skip_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (byte_done_w && !cmd_phase_w) |=>
                !(short_w[ch] && int'(ptr_w) == 2 * ch));
        end
    endgenerate
endmodule

bind spi_burst_port spi_burst_port_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_high_s   (cs_high_s),
    .byte_done_w (byte_done_w),
    .byte_val_w  (byte_val_w),
    .cmd_phase_w (cmd_phase_w),
    .ptr_w       (ptr_w),
    .short_w     (short_w),
    .rx_pop_o    (rx_pop_o),
    .tx_push_o   (tx_push_o),
    .tx_word_o   (tx_word_o)
);

// File: tb/spi_burst_port_tb_top.sv
module spi_burst_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [31:0] rx_head = {16'hC3E1, 16'h5A3C};
    logic [1:0]  rx_ne = 2'b00;
    logic [1:0]  tx_nf = 2'b00;
    logic [1:0]  rx_pop;
    logic [1:0]  tx_push;
    logic [15:0] tx_word;

    int n_cmp = 0;
    int n_bad = 0;
    int pops0 = 0;
    int pops1 = 0;
    int pushes = 0;
    logic [15:0] last_word = '0;
    logic [1:0]  last_ch = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_burst_port dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_sclk       (spi_sclk),
        .spi_cs_n       (spi_cs_n),
        .spi_mosi       (spi_mosi),
        .spi_miso       (spi_miso),
        .rx_head_i      (rx_head),
        .rx_not_empty_i (rx_ne),
        .tx_not_full_i  (tx_nf),
        .rx_pop_o       (rx_pop),
        .tx_push_o      (tx_push),
        .tx_word_o      (tx_word)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            pops0 += int'(rx_pop[0]);
            pops1 += int'(rx_pop[1]);
            if (tx_push != 2'b00) begin
                pushes++;
                last_word = tx_word;
                last_ch   = tx_push;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            rx[i] = spi_miso;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, input logic [7:0] exp, input string req, input string what);
        logic [7:0] rx;
        shift_bits(tx, 8, rx);
        check(req, what, 32'(rx), 32'(exp));
    endtask

    task automatic test_reset();
        check("R10", "miso idle after reset", 32'(spi_miso), 0);
        check("R10", "no pops after reset", 32'(pops0 + pops1), 0);
        check("R10", "no pushes after reset", 32'(pushes), 0);
    endtask

    task automatic test_write_burst();
        sel();
        xb(8'h87, 8'h5A, "R10", "cmd slot reads 0x00 (reset pointer)");
        xb(8'hA1, 8'h00, "R4", "old value of 0x07");
        xb(8'hA2, 8'h00, "R4", "old value of 0x08");
        xb(8'hA3, 8'h00, "R4", "old value of 0x09");
        desel();
    endtask

    task automatic test_read_burst();
        sel();
        xb(8'h67, 8'h00, "R4", "cmd slot reads 0x0A");
        xb(8'hFF, 8'hA1, "R1", "read of 0x07 with bits 6..5 set");
        xb(8'hFF, 8'hA2, "R2", "read of 0x08");
        xb(8'hFF, 8'hA3, "R11", "read of 0x09");
        xb(8'hFF, 8'h00, "R2", "read of 0x0A");
        desel();
        check("R7", "no pop for general registers", 32'(pops0 + pops1), 0);
    endtask

    task automatic test_wrap();
        sel();
        xb(8'h94, 8'h00, "R4", "cmd slot reads 0x0B");
        xb(8'h11, 8'h00, "R2", "write 0x14");
        xb(8'h22, 8'h00, "R2", "write 0x15");
        xb(8'h33, 8'h5A, "R3", "wrap to 0x00 reads rx high");
        xb(8'h44, 8'h3C, "R11", "0x01 reads rx low");
        check("R7", "pop channel 0", 32'(pops0), 1);
        check("R8", "push count", 32'(pushes), 1);
        check("R8", "push word hi:lo", 32'(last_word), 32'h3344);
        check("R8", "push channel", 32'(last_ch), 1);
        desel();
    endtask

    task automatic test_status();
        rx_ne = 2'b01;
        tx_nf = 2'b11;
        sel();
        xb(8'h03, 8'hC3, "R4", "cmd slot reads 0x02");
        rx_ne = 2'b00;
        tx_nf = 2'b00;
        xb(8'h00, 8'hE1, "R11", "0x03 reads rx low ch1");
        check("R7", "read pop channel 1", 32'(pops1), 1);
        check("R8", "read never pushes", 32'(pushes), 1);
        xb(8'h00, 8'h0B, "R5", "flag snapshot");
        desel();
    endtask

    task automatic test_short();
        sel();
        xb(8'h85, 8'h00, "R6", "cmd slot reads ctrl0");
        xb(8'h80, 8'h00, "R6", "ctrl0 old");
        xb(8'h80, 8'h00, "R6", "ctrl1 old");
        desel();
        sel();
        xb(8'h94, 8'hA1, "R4", "cmd slot reads 0x07");
        xb(8'h55, 8'h11, "R4", "old 0x14");
        xb(8'h66, 8'h22, "R4", "old 0x15");
        xb(8'h77, 8'h3C, "R6", "high ch0 skipped after wrap");
        check("R8", "short word ch0", 32'(last_word), 32'h0077);
        check("R7", "pop ch0 count", 32'(pops0), 2);
        xb(8'h88, 8'hE1, "R6", "high ch1 skipped");
        check("R8", "short word ch1", 32'(last_word), 32'h0088);
        check("R8", "push channel 1", 32'(last_ch), 2);
        check("R8", "push count", 32'(pushes), 3);
        check("R7", "pop ch1 count", 32'(pops1), 2);
        desel();
    endtask

    task automatic test_partial();
        logic [7:0] dummy;
        sel();
        xb(8'h81, 8'h00, "R5", "flags captured at this fall");
        shift_bits(8'h5B, 4, dummy);
        desel();
        check("R9", "partial byte no pop", 32'(pops0), 2);
        check("R9", "partial byte no push", 32'(pushes), 3);
        sel();
        xb(8'h07, 8'h3C, "R9", "pointer stays 0x01 after partial");
        check("R7", "command slot does not pop", 32'(pops0), 2);
        xb(8'h00, 8'hA1, "R2", "0x07 kept through read burst");
        desel();
    endtask

    task automatic test_unused();
        sel();
        xb(8'h96, 8'hA2, "R4", "cmd slot reads 0x08");
        xb(8'h99, 8'h00, "R3", "0x16 reads zero");
        desel();
        sel();
        xb(8'h16, 8'h3C, "R3", "advance from 0x16 wraps then skips");
        xb(8'h00, 8'h00, "R3", "write to 0x16 ignored");
        desel();
        check("R7", "no extra pops", 32'(pops0 + pops1), 4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog R1..: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        test_reset();
        test_write_burst();
        test_read_burst();
        test_wrap();
        test_status();
        test_short();
        test_partial();
        test_unused();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule